// File: doc/BRIEF.md
# TDMA Shared Parallel Bus Engine

This block moves fixed 24-bit packets between several identical nodes over one shared parallel bus. All nodes run from a common clock and a common reset. Each node keeps its own copy of a free-running slot counter, so the counters stay aligned without any arbitration. Time is split into slots of two clock cycles. Every node owns one slot index, and a node drives the bus only inside its own slot.

On the transmit side, the engine takes the head packet from a first-word-fall-through transmit FIFO and holds it. It then drives the packet, with a valid flag and an output enable, for the whole of the node's next slot. On the receive side, the engine samples the bus in the first cycle of every slot and filters each valid packet by its header nibbles. Every packet it accepts is pushed into a receive FIFO.

The transmitter runs a three-state machine:
- `TX_IDLE` pops a packet when the FIFO is not empty and moves to `TX_HOLD` (transition *fetch*).
- `TX_HOLD` moves to `TX_DRIVE` at the slot boundary whose next index equals the node's slot (transition *claim*).
- `TX_DRIVE` returns to `TX_IDLE` at the end of that slot (transition *release*).

Top module: `tdma_bus_engine`

## Requirements
- R1: A slot lasts exactly two clock cycles: a start cycle, then an end cycle. The slot index runs from 0 to `cfg_total`-1 and then wraps to 0. A `cfg_total` of 0 gives 16 slots. After reset, the index is 0 and the current cycle is a start cycle.
- R2: `bus_oe` and `bus_out_valid` are high for both cycles of a slot whose index equals `cfg_slot`, but only while a packet is held. In every other cycle both are low and `bus_out_data` is zero.
- R3: When the transmit FIFO is not empty and the engine is idle, the engine asserts `tx_pop` for one cycle and captures `tx_head`. It sends that packet in its next own slot. Packets go out in FIFO order, one per own slot at most.
- R4: Packet layout: bits [23:20] are the destination ID, bits [19:16] are the source ID, and bits [15:0] are the payload. The engine sends and stores packets unchanged.
- R5: The bus is sampled only in the start cycle of each slot. An accepted packet gives a one-cycle `rx_push`, with `rx_data` equal to the packet, in the following cycle. A packet present only in an end cycle is never taken.
- R6: A valid packet is accepted when its destination equals `cfg_addr` or is 0xF (broadcast). Any other destination is dropped, and a packet with `bus_in_valid` low is never taken.
- R7: A packet whose source equals `cfg_addr` is dropped, even when it is broadcast.
- R8: A packet that would be accepted while `rx_full` is high is dropped without `rx_push`, and `rx_overflow` is set. `rx_overflow` stays high until reset.
- R9: A change of `cfg_addr`, `cfg_slot` or `cfg_total` makes the slot index restart at 0 at the next slot boundary. A slot that is already being driven is finished first.
- R10: During reset, `bus_oe`, `bus_out_valid`, `bus_out_data`, `rx_push` and `rx_overflow` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock shared by all nodes |
| rst_n | input | 1 | Asynchronous active-low reset shared by all nodes |
| cfg_addr | input | 4 | This node's ID |
| cfg_slot | input | 4 | Slot index this node owns |
| cfg_total | input | 4 | Number of slots per round (0 means 16) |
| tx_empty | input | 1 | Transmit FIFO has no packet |
| tx_head | input | 24 | Head packet of the transmit FIFO |
| tx_pop | output | 1 | Removes the head packet from the transmit FIFO |
| bus_in_data | input | 24 | Resolved shared bus data |
| bus_in_valid | input | 1 | Resolved shared bus valid flag |
| bus_out_data | output | 24 | Data this node drives onto the bus |
| bus_out_valid | output | 1 | Valid flag this node drives |
| bus_oe | output | 1 | Output enable for this node's bus drivers |
| rx_full | input | 1 | Receive FIFO cannot take a packet |
| rx_push | output | 1 | Writes `rx_data` into the receive FIFO |
| rx_data | output | 24 | Accepted packet |
| rx_overflow | output | 1 | Sticky flag: an accepted packet was dropped because the FIFO was full |

## Verification
A slot counter that is off by one cycle shows up at once on the bus. `bus_oe` would then rise in an end cycle, or appear in a slot other than `cfg_slot`, and the bench sees this within one round of slots. A bad transmit state shows as a missing, doubled or reordered packet on `bus_out_data` at the next own slot, or as a `tx_pop` that arrives while the bus is driven. A bad receive filter shows on `rx_push` in the cycle right after the sampled slot start. A lost restart after reconfiguration shows as a drive in the wrong slot one boundary later.

// File: rtl/tdma_pkg.sv
`timescale 1ns/1ps
package tdma_pkg;
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_HOLD  = 2'd1,
        TX_DRIVE = 2'd2
    } tx_state_e;
endpackage

// File: rtl/tdma_slot_timer.sv
`timescale 1ns/1ps
module tdma_slot_timer #(
    parameter int SLOT_W = 4,
    parameter int CFG_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic [SLOT_W-1:0] cfg_total,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              slot_phase,
    output logic              slot_end,
    output logic [SLOT_W-1:0] next_idx
);
    logic [CFG_W-1:0]  cfg_prev;
    logic              primed;
    logic              restart_pend;
    logic              cfg_change;
    logic [SLOT_W-1:0] last_idx;

    assign cfg_change = primed && (cfg_word != cfg_prev);
    assign last_idx   = cfg_total - SLOT_W'(1);
    assign slot_end   = slot_phase;
    assign next_idx   = (restart_pend || cfg_change || slot_idx == last_idx)
                        ? '0 : slot_idx + SLOT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_phase   <= 1'b0;
            slot_idx     <= '0;
            cfg_prev     <= '0;
            primed       <= 1'b0;
            restart_pend <= 1'b0;
        end else begin
            slot_phase <= ~slot_phase;
            cfg_prev   <= cfg_word;
            primed     <= 1'b1;
            if (slot_end) begin
                slot_idx     <= next_idx;
                restart_pend <= 1'b0;
            end else if (cfg_change) begin
                restart_pend <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tdma_tx_fsm.sv
`timescale 1ns/1ps
module tdma_tx_fsm
    import tdma_pkg::*;
#(
    parameter int PKT_W  = 24,
    parameter int SLOT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_end,
    input  logic [SLOT_W-1:0] next_idx,
    input  logic [SLOT_W-1:0] my_slot,
    input  logic              tx_empty,
    input  logic [PKT_W-1:0]  tx_head,
    output logic              tx_pop,
    output logic              bus_oe,
    output logic              bus_valid,
    output logic [PKT_W-1:0]  bus_data
);
    tx_state_e        state_q, state_d;
    logic [PKT_W-1:0] pkt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            pkt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (tx_pop) pkt_q <= tx_head;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (!tx_empty) state_d = TX_HOLD;
            TX_HOLD:  if (slot_end && next_idx == my_slot) state_d = TX_DRIVE;
            TX_DRIVE: if (slot_end) state_d = TX_IDLE;
            default:  state_d = TX_IDLE;
        endcase
    end

    always_comb begin
        tx_pop    = (state_q == TX_IDLE) && !tx_empty;
        bus_oe    = (state_q == TX_DRIVE);
        bus_valid = (state_q == TX_DRIVE);
        bus_data  = (state_q == TX_DRIVE) ? pkt_q : '0;
    end
endmodule

// File: rtl/tdma_rx_filter.sv
`timescale 1ns/1ps
module tdma_rx_filter #(
    parameter int PKT_W = 24,
    parameter int ID_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_start,
    input  logic [ID_W-1:0]  my_addr,
    input  logic [PKT_W-1:0] bus_in_data,
    input  logic             bus_in_valid,
    input  logic             rx_full,
    output logic             rx_push,
    output logic [PKT_W-1:0] rx_data,
    output logic             rx_overflow
);
    localparam int DST_LO = PKT_W - ID_W;
    localparam int SRC_LO = PKT_W - 2 * ID_W;

    logic [ID_W-1:0] dst_id, src_id;
    logic            hit;

    assign dst_id = bus_in_data[PKT_W-1:DST_LO];
    assign src_id = bus_in_data[DST_LO-1:SRC_LO];
    assign hit    = slot_start && bus_in_valid
                    && ((dst_id == my_addr) || (dst_id == {ID_W{1'b1}}))
                    && (src_id != my_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_push     <= 1'b0;
            rx_data     <= '0;
            rx_overflow <= 1'b0;
        end else begin
            rx_push <= 1'b0;
            if (hit) begin
                if (rx_full) begin
                    rx_overflow <= 1'b1;
                end else begin
                    rx_push <= 1'b1;
                    rx_data <= bus_in_data;
                end
            end
        end
    end
endmodule

// File: rtl/tdma_bus_engine.sv
`timescale 1ns/1ps
module tdma_bus_engine #(
    parameter int PKT_W  = 24,
    parameter int ID_W   = 4,
    parameter int SLOT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   cfg_addr,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [SLOT_W-1:0] cfg_total,
    input  logic              tx_empty,
    input  logic [PKT_W-1:0]  tx_head,
    output logic              tx_pop,
    input  logic [PKT_W-1:0]  bus_in_data,
    input  logic              bus_in_valid,
    output logic [PKT_W-1:0]  bus_out_data,
    output logic              bus_out_valid,
    output logic              bus_oe,
    input  logic              rx_full,
    output logic              rx_push,
    output logic [PKT_W-1:0]  rx_data,
    output logic              rx_overflow
);
    localparam int CFG_W = ID_W + 2 * SLOT_W;

    logic [SLOT_W-1:0] slot_idx, next_idx;
    logic              slot_phase, slot_end;

    tdma_slot_timer #(.SLOT_W(SLOT_W), .CFG_W(CFG_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_word   ({cfg_addr, cfg_slot, cfg_total}),
        .cfg_total  (cfg_total),
        .slot_idx   (slot_idx),
        .slot_phase (slot_phase),
        .slot_end   (slot_end),
        .next_idx   (next_idx)
    );

    tdma_tx_fsm #(.PKT_W(PKT_W), .SLOT_W(SLOT_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_end  (slot_end),
        .next_idx  (next_idx),
        .my_slot   (cfg_slot),
        .tx_empty  (tx_empty),
        .tx_head   (tx_head),
        .tx_pop    (tx_pop),
        .bus_oe    (bus_oe),
        .bus_valid (bus_out_valid),
        .bus_data  (bus_out_data)
    );

    tdma_rx_filter #(.PKT_W(PKT_W), .ID_W(ID_W)) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .slot_start   (~slot_phase),
        .my_addr      (cfg_addr),
        .bus_in_data  (bus_in_data),
        .bus_in_valid (bus_in_valid),
        .rx_full      (rx_full),
        .rx_push      (rx_push),
        .rx_data      (rx_data),
        .rx_overflow  (rx_overflow)
    );
endmodule

// File: rtl/tdma_bus_chk.sv
`timescale 1ns/1ps
module tdma_bus_chk #(
    parameter int PKT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             slot_phase,
    input logic             bus_oe,
    input logic [PKT_W-1:0] bus_out_data,
    input logic             tx_pop,
    input logic             rx_push,
    input logic             rx_full,
    input logic             rx_overflow
);
    // R2
    drive_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> !slot_phase);
    // R2
    drive_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |=> (bus_oe && $stable(bus_out_data)));
    // R2
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_oe) |-> !slot_phase);
    // R3
    pop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !bus_oe);
    // R5
    push_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> slot_phase);
    // R8
    push_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !$past(rx_full));
    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rx_overflow) |-> rx_overflow);
endmodule

bind tdma_bus_engine tdma_bus_chk #(.PKT_W(PKT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .slot_phase   (slot_phase),
    .bus_oe       (bus_oe),
    .bus_out_data (bus_out_data),
    .tx_pop       (tx_pop),
    .rx_push      (rx_push),
    .rx_full      (rx_full),
    .rx_overflow  (rx_overflow)
);

// File: tb/tb_tdma_bus_engine.sv
`timescale 1ns/1ps
module tb_tdma_bus_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_addr = 4'h3, cfg_slot = 4'h2, cfg_total = 4'h4;
    logic        tx_empty, tx_pop;
    logic [23:0] tx_head;
    logic [23:0] bus_in_data = '0;
    logic        bus_in_valid = 1'b0;
    logic [23:0] bus_out_data, rx_data;
    logic        bus_out_valid, bus_oe;
    logic        rx_full = 1'b0;
    logic        rx_push, rx_overflow;

    logic [23:0] q [4];
    logic [2:0]  q_head = '0;
    logic [2:0]  q_n = 3'd2;
    int          cyc = 0;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    // RX table: {valid, packet, expect_push}; node ID 3
    localparam logic [25:0] RX_VEC [6] = '{
        {1'b1, 24'h35A1B2, 1'b1},   // R6 unicast to 3 from 5
        {1'b1, 24'hF5C3D4, 1'b1},   // R6 broadcast from 5
        {1'b1, 24'h451111, 1'b0},   // R6 other destination
        {1'b0, 24'h352222, 1'b0},   // R6 not valid
        {1'b1, 24'h333333, 1'b0},   // R7 own source
        {1'b1, 24'hF34444, 1'b0}    // R7 own source, broadcast
    };

    always #10 clk = ~clk;

    assign tx_empty = (q_head >= q_n);
    assign tx_head  = q[q_head[1:0]];

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else cyc <= cyc + 1;
        if (rst_n && tx_pop) q_head <= q_head + 3'd1;
    end

    tdma_bus_engine dut (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_slot(cfg_slot),
        .cfg_total(cfg_total), .tx_empty(tx_empty), .tx_head(tx_head),
        .tx_pop(tx_pop), .bus_in_data(bus_in_data), .bus_in_valid(bus_in_valid),
        .bus_out_data(bus_out_data), .bus_out_valid(bus_out_valid), .bus_oe(bus_oe),
        .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_data),
        .rx_overflow(rx_overflow)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic to_phase(input int modv, input int val);
        @(negedge clk);
        while ((cyc % modv) != val) @(negedge clk);
    endtask

    initial begin
        q[0] = 24'h23BEEF;
        q[1] = 24'hF30042;
        q[2] = 24'h137777;
        q[3] = 24'h000000;
        repeat (3) @(negedge clk);
        // R10 reset values
        chk("R10 oe", {31'd0, bus_oe}, 32'd0);
        chk("R10 valid", {31'd0, bus_out_valid}, 32'd0);
        chk("R10 data", {8'd0, bus_out_data}, 32'd0);
        chk("R10 push", {31'd0, rx_push}, 32'd0);
        chk("R10 overflow", {31'd0, rx_overflow}, 32'd0);
        rst_n = 1'b1;

        // R1 R2 R3 R4: slot 2 of 4, two packets, slot lasts 2 cycles
        for (int i = 0; i < 24; i++) begin
            logic        e_oe;
            logic [23:0] e_d;
            e_oe = (i == 4 || i == 5 || i == 12 || i == 13);
            e_d  = (i == 4 || i == 5) ? q[0] : (e_oe ? q[1] : 24'd0);
            chk("R1/R2 oe", {31'd0, bus_oe}, {31'd0, e_oe});
            chk("R2 valid", {31'd0, bus_out_valid}, {31'd0, e_oe});
            chk("R3/R4 data", {8'd0, bus_out_data}, {8'd0, e_d});
            @(negedge clk);
        end
        chk("R3 popped both", {29'd0, q_head}, 32'd2);

        // R5 R6 R7 table walk
        for (int k = 0; k < 6; k++) begin
            to_phase(2, 0);
            bus_in_valid = RX_VEC[k][25];
            bus_in_data  = RX_VEC[k][24:1];
            @(negedge clk);
            bus_in_valid = 1'b0;
            chk("R5/R6/R7 push", {31'd0, rx_push}, {31'd0, RX_VEC[k][0]});
            if (RX_VEC[k][0])
                chk("R4/R5 rx_data", {8'd0, rx_data}, {8'd0, RX_VEC[k][24:1]});
        end

        // R5 packet only in end cycle is not taken
        to_phase(2, 1);
        bus_in_valid = 1'b1;
        bus_in_data  = 24'h35ABCD;
        @(negedge clk);
        bus_in_valid = 1'b0;
        chk("R5 end-cycle push", {31'd0, rx_push}, 32'd0);
        @(negedge clk);
        chk("R5 end-cycle push late", {31'd0, rx_push}, 32'd0);

        // R8 overflow
        to_phase(2, 0);
        rx_full = 1'b1;
        bus_in_valid = 1'b1;
        bus_in_data  = 24'h359999;
        @(negedge clk);
        bus_in_valid = 1'b0;
        rx_full = 1'b0;
        chk("R8 drop when full", {31'd0, rx_push}, 32'd0);
        chk("R8 overflow set", {31'd0, rx_overflow}, 32'd1);
        to_phase(2, 0);
        bus_in_valid = 1'b1;
        bus_in_data  = 24'hF55555;
        @(negedge clk);
        bus_in_valid = 1'b0;
        chk("R8 push after full", {31'd0, rx_push}, 32'd1);
        chk("R8 overflow sticky", {31'd0, rx_overflow}, 32'd1);

        // R9 restart: slot 0 change at start of slot 0, natural next is 1
        to_phase(8, 0);
        cfg_slot = 4'h0;
        q_n = 3'd3;
        @(negedge clk);
        chk("R9 oe before boundary", {31'd0, bus_oe}, 32'd0);
        @(negedge clk);
        chk("R9 restart oe", {31'd0, bus_oe}, 32'd1);
        chk("R9 restart data", {8'd0, bus_out_data}, {8'd0, q[2]});
        @(negedge clk);
        chk("R9 second cycle", {31'd0, bus_oe}, 32'd1);
        @(negedge clk);
        chk("R9 released", {31'd0, bus_oe}, 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=hung exp=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule